// File: doc/BRIEF.md
# UART Modem-Control Loopback Mapper

This block sits beside a UART control register and serves its internal loopback test mode. When software writes the control register with loopback enabled, the block copies the four software-driven modem outputs onto the four modem status flags. It uses a fixed crossed mapping: RTS drives CTS, DTR drives DSR, Out1 drives DCD and Out2 drives RI. On the same write it sends the interrupt status register a one-cycle command. The command clears the whole modem interrupt group and then sets one bit for each flag that is now high. As a result, the modem interrupt group always matches the flags that software has just looped back.

The block also watches writes to the line-control register. When the send-break control goes from 0 to 1 while loopback is enabled, the block hands the receive FIFO one word with only its break marker set. With loopback disabled, control writes leave the flags and interrupt bits alone. Effects of hardware flow control and sampling of the external modem pins are handled elsewhere.

Top module: `uart_mdm_loop`

## Requirements
- R1: A control write (`ctrl_wr`=1) with `lb_en`=1 sets `cts` to the written `rts` and `dsr` to the written `dtr`. The new values are visible in the cycle after the write edge and are held until the next such write.
- R2: On the same kind of write, `ri` takes the written `out2` value and `dcd` takes the written `out1` value, with the same timing as R1.
- R3: The mapping is applied by the very write that sets `lb_en`, whether or not loopback was enabled before.
- R4: In the same cycle that the flags change, the block pulses `msi_clr`=4'b1111 and `msi_set` equal to the new flags for one cycle. The bit order is bit 0 RI, bit 1 CTS, bit 2 DCD, bit 3 DSR.
- R5: A control write with `lb_en`=0 leaves all four flags unchanged, and `msi_set` and `msi_clr` stay 0.
- R6: In a cycle with no control write, the flags hold and `msi_set` and `msi_clr` are 0.
- R7: A line-control write (`line_wr`=1) with `brk_bit`=1, where the previously written break value was 0 and `lb_en`=1, gives `rx_push`=1 for exactly one cycle after the edge. At that time `rx_word` has only bit DATA_W+2 set (12'h400 with DATA_W=8).
- R8: No push happens in three cases: when `lb_en`=0, when the break value was already 1, or when the break value falls to 0. In every case the stored break value still follows each line-control write, and `rx_word` is 0 whenever `rx_push` is 0.
- R9: While reset is asserted and after it is released, all flags, `msi_set`, `msi_clr`, `rx_push` and `rx_word` are 0, and the stored break value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| lb_en | input | 1 | Loopback enable field of the control register |
| rts | input | 1 | RTS output field |
| dtr | input | 1 | DTR output field |
| out1 | input | 1 | Out1 output field |
| out2 | input | 1 | Out2 output field |
| line_wr | input | 1 | Line-control register write strobe |
| brk_bit | input | 1 | Send-break field being written |
| cts | output | 1 | CTS status flag |
| dsr | output | 1 | DSR status flag |
| dcd | output | 1 | DCD status flag |
| ri | output | 1 | RI status flag |
| msi_set | output | 4 | Modem interrupt set pulse (bit0 RI, 1 CTS, 2 DCD, 3 DSR) |
| msi_clr | output | 4 | Modem interrupt clear pulse, applied before set |
| rx_push | output | 1 | Push a word into the receive FIFO |
| rx_word | output | DATA_W+4 | Word to push; break marker at bit DATA_W+2 |

## Verification
Every result is due in the cycle after the edge that sampled its strobe. The flags change there and stay changed, while `msi_set`, `msi_clr` and `rx_push` are high for that one cycle only. The driver changes inputs on the falling edge and queues, for each step, the values expected just after the next rising edge. The monitor samples a quarter period after that rising edge and pops exactly one entry per cycle, so a pulse that comes early, comes late or lasts two cycles fails against its neighbouring entry.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int unsigned MDM_N = 4;

    // bit 0 RI, 1 CTS, 2 DCD, 3 DSR: the interrupt group order
    typedef struct packed {
        logic dsr;
        logic dcd;
        logic cts;
        logic ri;
    } mdm_flags_t;
endpackage

// File: rtl/lbk_mdm_map.sv
module lbk_mdm_map
    import lbk_pkg::*;
(
    input  logic             apply,
    input  logic             rts,
    input  logic             dtr,
    input  logic             out1,
    input  logic             out2,
    input  mdm_flags_t       flags_cur,
    output mdm_flags_t       flags_nxt,
    output logic [MDM_N-1:0] set_nxt,
    output logic [MDM_N-1:0] clr_nxt
);
    mdm_flags_t looped;

    always_comb begin
        looped.ri  = out2;
        looped.dcd = out1;
        looped.cts = rts;
        looped.dsr = dtr;
        if (apply) begin
            flags_nxt = looped;
            clr_nxt   = '1;
            set_nxt   = looped;
        end else begin
            flags_nxt = flags_cur;
            clr_nxt   = '0;
            set_nxt   = '0;
        end
    end
endmodule

// File: rtl/lbk_brk_feed.sv
module lbk_brk_feed #(
    parameter int unsigned WORD_W  = 12,
    parameter int unsigned BRK_POS = 10
) (
    input  logic              line_wr,
    input  logic              brk_bit,
    input  logic              lb_en,
    input  logic              brk_cur,
    output logic              brk_nxt,
    output logic              push_nxt,
    output logic [WORD_W-1:0] word_nxt
);
    always_comb begin
        brk_nxt  = line_wr ? brk_bit : brk_cur;
        push_nxt = line_wr && brk_bit && !brk_cur && lb_en;
        word_nxt = '0;
        if (push_nxt) word_nxt[BRK_POS] = 1'b1;
    end
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
    import lbk_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                lb_en,
    input  logic                rts,
    input  logic                dtr,
    input  logic                out1,
    input  logic                out2,
    input  logic                line_wr,
    input  logic                brk_bit,
    output logic                cts,
    output logic                dsr,
    output logic                dcd,
    output logic                ri,
    output logic [MDM_N-1:0]    msi_set,
    output logic [MDM_N-1:0]    msi_clr,
    output logic                rx_push,
    output logic [DATA_W+3:0]   rx_word
);
    localparam int unsigned WORD_W  = DATA_W + 4;
    localparam int unsigned BRK_POS = DATA_W + 2;

    typedef struct packed {
        mdm_flags_t        flags;
        logic [MDM_N-1:0]  set;
        logic [MDM_N-1:0]  clr;
        logic              brk;
        logic              push;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t st_d, st_q;

    mdm_flags_t       map_flags;
    logic [MDM_N-1:0] map_set, map_clr;
    logic             bf_brk, bf_push;
    logic [WORD_W-1:0] bf_word;

    lbk_mdm_map u_map (
        .apply     (ctrl_wr && lb_en),
        .rts       (rts),
        .dtr       (dtr),
        .out1      (out1),
        .out2      (out2),
        .flags_cur (st_q.flags),
        .flags_nxt (map_flags),
        .set_nxt   (map_set),
        .clr_nxt   (map_clr)
    );

    lbk_brk_feed #(.WORD_W(WORD_W), .BRK_POS(BRK_POS)) u_brk (
        .line_wr  (line_wr),
        .brk_bit  (brk_bit),
        .lb_en    (lb_en),
        .brk_cur  (st_q.brk),
        .brk_nxt  (bf_brk),
        .push_nxt (bf_push),
        .word_nxt (bf_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = map_flags;
        st_d.set   = map_set;
        st_d.clr   = map_clr;
        st_d.brk   = bf_brk;
        st_d.push  = bf_push;
        st_d.word  = bf_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cts     = st_q.flags.cts;
    assign dsr     = st_q.flags.dsr;
    assign dcd     = st_q.flags.dcd;
    assign ri      = st_q.flags.ri;
    assign msi_set = st_q.set;
    assign msi_clr = st_q.clr;
    assign rx_push = st_q.push;
    assign rx_word = st_q.word;

    // R1 R2 R3
    map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ctrl_wr && lb_en) |->
            cts == $past(rts) && dsr == $past(dtr) &&
            dcd == $past(out1) && ri == $past(out2));

    // R5 R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ctrl_wr && lb_en) |->
            $stable({dsr, dcd, cts, ri}) && msi_set == '0 && msi_clr == '0);

    // R4
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_clr != '0 |-> msi_clr == '1 && msi_set == {dsr, dcd, cts, ri});

    // R7
    brk_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $countones(rx_word) == 1 && rx_word[BRK_POS]);

    // R7 R8
    brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    // R8
    brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_push |-> rx_word == '0);
endmodule

// File: tb/uart_mdm_loop_test.sv
module uart_mdm_loop_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, lb_en = 0, rts = 0, dtr = 0, out1 = 0, out2 = 0;
    logic line_wr = 0, brk_bit = 0;
    logic cts, dsr, dcd, ri, rx_push;
    logic [3:0] msi_set, msi_clr;
    logic [11:0] rx_word;

    always #10 clk = ~clk;

    uart_mdm_loop #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .lb_en(lb_en),
        .rts(rts), .dtr(dtr), .out1(out1), .out2(out2),
        .line_wr(line_wr), .brk_bit(brk_bit),
        .cts(cts), .dsr(dsr), .dcd(dcd), .ri(ri),
        .msi_set(msi_set), .msi_clr(msi_clr),
        .rx_push(rx_push), .rx_word(rx_word)
    );

    typedef struct {
        logic [3:0]  fl;
        logic [3:0]  st;
        logic [3:0]  cl;
        logic        push;
        logic [11:0] word;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;
    logic done = 0;
    logic [3:0] m_fl = 4'h0;
    logic m_brk = 1'b0;

    task automatic step(input logic w, input logic lb, input logic r, input logic d,
                        input logic o1, input logic o2, input logic lw, input logic bk,
                        input string tag);
        exp_t e;
        @(negedge clk);
        ctrl_wr = w; lb_en = lb; rts = r; dtr = d; out1 = o1; out2 = o2;
        line_wr = lw; brk_bit = bk;
        if (w && lb) begin
            m_fl = {d, o1, r, o2};
            e.st = m_fl;
            e.cl = 4'hF;
        end else begin
            e.st = 4'h0;
            e.cl = 4'h0;
        end
        e.fl   = m_fl;
        e.push = lw && bk && !m_brk && lb;
        if (lw) m_brk = bk;
        e.word = e.push ? 12'h400 : 12'h000;
        e.tag  = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if ({dsr, dcd, cts, ri} !== e.fl || msi_set !== e.st || msi_clr !== e.cl ||
                rx_push !== e.push || rx_word !== e.word) begin
                bad++;
                $display("FAIL %s: got fl=%h set=%h clr=%h push=%b word=%h exp fl=%h set=%h clr=%h push=%b word=%h",
                         e.tag, {dsr, dcd, cts, ri}, msi_set, msi_clr, rx_push, rx_word,
                         e.fl, e.st, e.cl, e.push, e.word);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs are 0 while reset is held
        total++;
        if ({dsr, dcd, cts, ri, msi_set, msi_clr, rx_push} !== '0 || rx_word !== '0) begin
            bad++;
            $display("FAIL R9: got nonzero outputs in reset exp 0");
        end
        rst_n = 1'b1;
        step(0,0,0,0,0,0,0,0, "R9");
        step(1,1,1,0,0,0,0,0, "R3 R1 cts");
        step(0,1,0,0,0,0,0,0, "R6");
        step(1,1,0,1,0,0,0,0, "R1 dsr");
        step(1,1,0,0,1,1,0,0, "R2");
        step(1,1,1,1,1,1,0,0, "R4 all set");
        step(1,1,0,0,0,0,0,0, "R4 all clear");
        step(1,0,1,1,1,1,0,0, "R5");
        step(1,1,1,0,1,0,0,0, "R1 R2 mix");
        step(1,0,0,1,0,1,0,0, "R5 hold");
        step(0,0,0,0,0,0,0,0, "R6 idle");
        step(0,1,0,0,0,0,1,1, "R7 rise");
        step(0,1,0,0,0,0,1,1, "R8 already set");
        step(0,1,0,0,0,0,1,0, "R8 fall");
        step(0,0,0,0,0,0,1,1, "R8 loopback off");
        step(0,1,0,0,0,0,1,0, "R8 fall again");
        step(1,1,0,1,1,0,1,1, "R7 R4 together");
        step(0,1,0,0,0,0,0,0, "R7 one cycle");
        step(0,0,0,0,0,0,0,0, "R6 end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule